// File: doc/BRIEF.md
# APB Completer Port Compliance Monitor

This block is a passive observer attached to the control signals of a single APB completer port. In every clock cycle it sorts the bus into one of three phases: idle (select low), setup (select high, enable low) or access (select and enable both high). It then checks the order in which these phases occur and flags three kinds of fault: a setup that is not followed by an access, a wait state that runs too long, and a bus that does not go idle after a completion. It has no outputs toward the bus and never drives it.

Each rule has its own error flag. A flag stays set until reset, so firmware or a test harness can read the rule that broke long after the event. When a transfer completes, the monitor raises a one-cycle pulse. It also counts write and read transfers in two separate counters, and each counter saturates at its maximum value. A fourth flag catches a direction signal that changes between the setup cycle and the access cycle. Reset is synchronous and active low, and it clears all state.

Top module: `apb_watch`

## Requirements
- R1: While rst_n is low, at the next clock edge every error flag is cleared, both counters are set to zero and xfer_done is set low. All of these stay at those values for as long as rst_n is held low.
- R2: A setup cycle (psel=1, penable=0) may be followed by any cycle that is not an access cycle (psel=1, penable=1). In that case err_setup is set, and it is first visible in the cycle after the offending cycle.
- R3: The access cycles of a transfer are numbered from offset 0 up to offset MAX_WAIT-1 (default 16). If pready is low in all of them, err_timeout is set and is visible in the cycle after offset MAX_WAIT-1. If pready is high at offset MAX_WAIT-1 or earlier, err_timeout is not set.
- R4: Consider an access cycle with pready=1 that belongs to a transfer. If psel is not low in the cycle that follows it, err_idle is set, and it is visible one cycle after that cycle.
- R5: A complete transfer is a setup cycle, then one or more access cycles ending in pready=1, then an idle cycle. One cycle after the idle cycle, xfer_done is high for exactly one cycle. In that same cycle wr_count goes up by one if pwrite was 1 in the setup cycle and in the access cycles. Otherwise rd_count goes up by one if pwrite was 0 in all of those cycles.
- R6: The access cycle that directly follows a setup cycle may have a pwrite value that differs from the setup cycle. In that case err_ctrl is set. A transfer whose pwrite changed is still reported by xfer_done, but neither counter increments for it.
- R7: Every error flag stays high until reset once it is set. A violation of one rule sets only the flag for that rule.
- R8: wr_count and rd_count are CNT_W bits wide (default 16) and hold at 2^CNT_W-1 when further transfers complete.
- R9: Access cycles that are not preceded by a setup cycle are not a transfer. They produce no xfer_done pulse and no change to either counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| psel | input | 1 | Observed completer select |
| penable | input | 1 | Observed enable |
| pwrite | input | 1 | Observed direction, 1 = write |
| pready | input | 1 | Observed completer ready |
| err_setup | output | 1 | Sticky: setup not followed by access |
| err_timeout | output | 1 | Sticky: no pready within the wait window |
| err_ctrl | output | 1 | Sticky: pwrite changed from setup to access |
| err_idle | output | 1 | Sticky: select not low after completion |
| xfer_done | output | 1 | One-cycle pulse per completed transfer |
| wr_count | output | CNT_W | Saturating count of completed writes |
| rd_count | output | CNT_W | Saturating count of completed reads |

## Verification
If the record of the previous cycle's phase is wrong, err_setup or err_idle misfires, and it does so in the cycle right after the cycle that was misjudged. An error in the wait counter moves the timeout by one or more cycles, so the bench checks at offset MAX_WAIT-2, where err_timeout must still be low, and at MAX_WAIT-1, where it must be high. A wrong direction record sends a completed transfer to the wrong counter, or to neither counter, and this is visible in the same cycle as the xfer_done pulse.

// File: rtl/apb_watch_pkg.sv
package apb_watch_pkg;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_SETUP = 2'd1, PH_ACCESS = 2'd2} phase_t;

  function automatic phase_t classify(input logic sel, input logic en);
    if (!sel) return PH_IDLE;
    else if (!en) return PH_SETUP;
    else return PH_ACCESS;
  endfunction
endpackage

// File: rtl/apb_watch_wait.sv
module apb_watch_wait #(
  parameter int MAX_WAIT = 16,
  localparam int WW = $clog2(MAX_WAIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_access,
  input  logic          pready,
  output logic          tmo_hit,
  output logic [WW-1:0] wcnt
);
  logic fired;
  localparam logic [WW-1:0] LAST = WW'(MAX_WAIT - 1);

  assign tmo_hit = in_access && !pready && (wcnt == LAST) && !fired;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt  <= '0;
      fired <= 1'b0;
    end else if (!in_access || pready) begin
      wcnt  <= '0;
      fired <= 1'b0;
    end else if (wcnt == LAST) begin
      fired <= 1'b1;
    end else begin
      wcnt <= wcnt + 1'b1;
    end
  end
endmodule

// File: rtl/apb_watch_count.sv
module apb_watch_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (inc && (q != {W{1'b1}})) q <= q + 1'b1;
  end
endmodule

// File: rtl/apb_watch_phase.sv
module apb_watch_phase
  import apb_watch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic psel,
  input  logic penable,
  input  logic pwrite,
  input  logic pready,
  input  logic tmo_hit,
  output logic in_access,
  output logic inc_wr,
  output logic inc_rd,
  output logic err_setup,
  output logic err_timeout,
  output logic err_ctrl,
  output logic err_idle,
  output logic xfer_done
);
  phase_t ph;
  logic prev_setup, setup_pw, in_xfer, pw_match;
  logic done_pend, done_good;
  logic started_now, ok_now, finish_now;

  assign ph          = classify(psel, penable);
  assign in_access   = (ph == PH_ACCESS);
  assign started_now = in_access && (prev_setup || in_xfer);
  assign ok_now      = in_access && (pwrite == setup_pw) && (prev_setup || (in_xfer && pw_match));
  assign finish_now  = done_pend && (ph == PH_IDLE);
  assign inc_wr      = finish_now && done_good && setup_pw;
  assign inc_rd      = finish_now && done_good && !setup_pw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_setup  <= 1'b0;
      setup_pw    <= 1'b0;
      in_xfer     <= 1'b0;
      pw_match    <= 1'b0;
      done_pend   <= 1'b0;
      done_good   <= 1'b0;
      err_setup   <= 1'b0;
      err_timeout <= 1'b0;
      err_ctrl    <= 1'b0;
      err_idle    <= 1'b0;
      xfer_done   <= 1'b0;
    end else begin
      prev_setup <= (ph == PH_SETUP);
      if (ph == PH_SETUP) setup_pw <= pwrite;
      in_xfer   <= started_now && !pready;
      pw_match  <= ok_now;
      done_pend <= started_now && pready;
      if (started_now && pready) done_good <= ok_now;
      xfer_done <= finish_now;
      if (prev_setup && !in_access) err_setup <= 1'b1;
      if (prev_setup && in_access && (pwrite != setup_pw)) err_ctrl <= 1'b1;
      if (done_pend && (ph != PH_IDLE)) err_idle <= 1'b1;
      if (tmo_hit) err_timeout <= 1'b1;
    end
  end
endmodule

// File: rtl/apb_watch.sv
module apb_watch #(
  parameter int CNT_W    = 16,
  parameter int MAX_WAIT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic             pready,
  output logic             err_setup,
  output logic             err_timeout,
  output logic             err_ctrl,
  output logic             err_idle,
  output logic             xfer_done,
  output logic [CNT_W-1:0] wr_count,
  output logic [CNT_W-1:0] rd_count
);
  localparam int WW = $clog2(MAX_WAIT + 1);

  logic          in_access, tmo_hit, inc_wr, inc_rd;
  logic [WW-1:0] wait_cnt;
  logic [1:0]    incs;
  logic [CNT_W-1:0] cnts [2];

  apb_watch_phase u_phase (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .pready(pready), .tmo_hit(tmo_hit),
    .in_access(in_access), .inc_wr(inc_wr), .inc_rd(inc_rd),
    .err_setup(err_setup), .err_timeout(err_timeout),
    .err_ctrl(err_ctrl), .err_idle(err_idle), .xfer_done(xfer_done)
  );

  apb_watch_wait #(.MAX_WAIT(MAX_WAIT)) u_wait (
    .clk(clk), .rst_n(rst_n), .in_access(in_access), .pready(pready),
    .tmo_hit(tmo_hit), .wcnt(wait_cnt)
  );

  assign incs = {inc_rd, inc_wr};

  for (genvar i = 0; i < 2; i++) begin : g_cnt
    apb_watch_count #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(incs[i]), .q(cnts[i])
    );
  end

  assign wr_count = cnts[0];
  assign rd_count = cnts[1];
endmodule

// File: rtl/apb_watch_chk.sv
module apb_watch_chk #(
  parameter int CNT_W    = 16,
  parameter int MAX_WAIT = 16,
  localparam int WW = $clog2(MAX_WAIT + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             psel,
  input logic             penable,
  input logic             pready,
  input logic             err_setup,
  input logic             err_timeout,
  input logic             err_ctrl,
  input logic             err_idle,
  input logic             xfer_done,
  input logic [CNT_W-1:0] wr_count,
  input logic [CNT_W-1:0] rd_count,
  input logic [WW-1:0]    wait_cnt
);
  AST_SETUP_TO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable) ##1 !(psel && penable) |=> err_setup); // R2

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= WW'(MAX_WAIT - 1)); // R3

  AST_IDLE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pready) ##1 psel |=> err_idle); // R4

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done); // R5

  AST_WR_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_count) |-> xfer_done); // R5

  AST_RD_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_count) |-> xfer_done); // R5

  AST_STICKY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_setup || err_timeout || err_ctrl || err_idle) |=>
    ($past(err_setup) <= err_setup) && ($past(err_timeout) <= err_timeout) &&
    ($past(err_ctrl) <= err_ctrl) && ($past(err_idle) <= err_idle)); // R7

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_count) <= wr_count) && ($past(rd_count) <= rd_count)); // R8
endmodule

bind apb_watch apb_watch_chk #(.CNT_W(CNT_W), .MAX_WAIT(MAX_WAIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pready(pready),
  .err_setup(err_setup), .err_timeout(err_timeout), .err_ctrl(err_ctrl),
  .err_idle(err_idle), .xfer_done(xfer_done), .wr_count(wr_count),
  .rd_count(rd_count), .wait_cnt(wait_cnt)
);

// File: tb/tb_apb_watch.sv
module tb_apb_watch;
  localparam int CW = 4;
  localparam int MW = 16;
  localparam time HALF = 10ns;

  logic clk = 1'b0;
  logic rst_n, psel, penable, pwrite, pready;
  logic err_setup, err_timeout, err_ctrl, err_idle, xfer_done;
  logic [CW-1:0] wr_count, rd_count;
  int n_checks = 0;
  int n_fails = 0;

  always #HALF clk = ~clk;

  apb_watch #(.CNT_W(CW), .MAX_WAIT(MW)) dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .pready(pready), .err_setup(err_setup),
    .err_timeout(err_timeout), .err_ctrl(err_ctrl), .err_idle(err_idle),
    .xfer_done(xfer_done), .wr_count(wr_count), .rd_count(rd_count)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one bus cycle; afterwards the outputs reflect that cycle
  task automatic step(input logic s, input logic e, input logic w, input logic r);
    psel = s; penable = e; pwrite = w; pready = r;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(0, 0, 0, 0);
    step(1, 1, 1, 1);
    rst_n = 1'b1;
    step(0, 0, 0, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step(1, 0, 1, 0);
    step(0, 0, 1, 0);
    chk("R1 err flags", {err_setup, err_timeout, err_ctrl, err_idle}, 0);
    chk("R1 counters", wr_count + rd_count, 0);
    chk("R1 xfer_done", xfer_done, 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0);
  endtask

  task automatic t_write();
    step(1, 0, 1, 0);
    step(1, 1, 1, 1);
    chk("R5 no pulse before idle", xfer_done, 0);
    step(0, 0, 0, 0);
    chk("R5 write pulse", xfer_done, 1);
    chk("R5 wr_count", wr_count, 1);
    chk("R5 rd_count untouched", rd_count, 0);
    step(0, 0, 0, 0);
    chk("R5 pulse one cycle", xfer_done, 0);
  endtask

  task automatic t_read_waits();
    step(1, 0, 0, 0);
    for (int i = 0; i < MW - 1; i++) step(1, 1, 0, 0);
    step(1, 1, 0, 1);
    step(0, 0, 0, 0);
    chk("R3 ready at last offset no timeout", err_timeout, 0);
    chk("R5 rd_count", rd_count, 1);
    chk("R5 wr_count unchanged", wr_count, 1);
  endtask

  task automatic t_no_setup();
    step(1, 1, 1, 1);
    step(0, 0, 0, 0);
    chk("R9 no pulse", xfer_done, 0);
    chk("R9 wr_count unchanged", wr_count, 1);
    chk("R9 no idle error", err_idle, 0);
  endtask

  task automatic t_timeout();
    do_reset();
    step(1, 0, 1, 0);
    for (int i = 0; i < MW - 1; i++) step(1, 1, 1, 0);
    chk("R3 no timeout through offset MW-2", err_timeout, 0);
    step(1, 1, 1, 0);
    chk("R3 timeout after offset MW-1", err_timeout, 1);
    step(1, 1, 1, 0);
    step(1, 1, 1, 1);
    step(0, 0, 0, 0);
    chk("R7 timeout sticky", err_timeout, 1);
    chk("R7 only timeout flag", {err_setup, err_ctrl, err_idle}, 0);
  endtask

  task automatic t_setup_err();
    do_reset();
    step(1, 0, 0, 0);
    step(0, 0, 0, 0);
    chk("R2 setup then idle", err_setup, 1);
    chk("R7 only setup flag", {err_timeout, err_ctrl, err_idle}, 0);
    step(0, 0, 0, 0);
    chk("R7 setup sticky", err_setup, 1);
    do_reset();
    step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    chk("R2 setup then setup", err_setup, 1);
  endtask

  task automatic t_ctrl_err();
    do_reset();
    step(1, 0, 1, 0);
    step(1, 1, 0, 1);
    chk("R6 ctrl flag", err_ctrl, 1);
    step(0, 0, 0, 0);
    chk("R6 pulse still given", xfer_done, 1);
    chk("R6 no count", wr_count + rd_count, 0);
    chk("R7 only ctrl flag", {err_setup, err_timeout, err_idle}, 0);
  endtask

  task automatic t_idle_err();
    do_reset();
    step(1, 0, 0, 0);
    step(1, 1, 0, 1);
    step(1, 0, 0, 0);
    chk("R4 idle missing", err_idle, 1);
    chk("R4 no pulse", xfer_done, 0);
    step(1, 1, 0, 1);
    step(0, 0, 0, 0);
    chk("R7 only idle flag", {err_setup, err_timeout, err_ctrl}, 0);
    chk("R4 following transfer counted", rd_count, 1);
  endtask

  task automatic t_saturate();
    do_reset();
    for (int i = 0; i < (1 << CW) + 2; i++) begin
      step(1, 0, 1, 0);
      step(1, 1, 1, 1);
      step(0, 0, 0, 0);
    end
    chk("R8 wr_count saturates", wr_count, (1 << CW) - 1);
    chk("R8 rd_count untouched", rd_count, 0);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(2 * HALF * 100000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; psel = 0; penable = 0; pwrite = 0; pready = 0;
    @(negedge clk);
    t_reset();
    t_write();
    t_read_waits();
    t_no_setup();
    t_timeout();
    t_setup_err();
    t_ctrl_err();
    t_idle_err();
    t_saturate();
    finish_up();
  end
endmodule